// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This unit computes the full 64-bit product or the quotient and remainder of two 32-bit integers. Operands are taken as unsigned or as two's complement. It uses one shared adder/subtractor and one shift register pair, and retires one partial step per clock. Multiplication uses shift-and-add over the multiplier bits. Division uses the restoring method on operand magnitudes, and the signs are corrected in a final cycle. The result lands in a high/low register pair. After a multiply, the pair holds the upper and lower halves of the product. After a divide, the high register holds the remainder and the low register holds the quotient.

A request is offered with `req_valid` and is taken on a rising clock edge where `req_ready` is also high. `req_ready` is high only while the unit is idle, so a request offered while busy is not taken and has no effect; the requester must hold it until `req_ready` returns. The result side has no back-pressure. `done` pulses for one cycle when `res_hi`/`res_lo` take a new value, and the pair then holds until the next completion. No overflow or divide-by-zero indication exists.

Top module: `muldiv_seq`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A request is taken on an edge where `req_valid` and `req_ready` are both high. A request offered while busy is ignored: it produces no result and no later `done`.
- R2: `busy` rises in the cycle after the accepting edge. `done` is a single-cycle pulse that rises on the 34th rising edge after the accepting edge: one setup step, 32 iteration steps and one sign-fix step. `busy` falls on that same edge.
- R3: With `req_op`=0 (multiply) and `req_signed`=0, {`res_hi`,`res_lo`} equals the 64-bit unsigned product of `req_a` and `req_b`.
- R4: With `req_op`=0 and `req_signed`=1, {`res_hi`,`res_lo`} equals the 64-bit two's complement product. It is formed from operand magnitudes and negated when the operand signs differ.
- R5: With `req_op`=1 (divide), `req_signed`=0 and a non-zero divisor, `res_lo` is `req_a / req_b` and `res_hi` is `req_a % req_b`. Both are unsigned.
- R6: With `req_op`=1, `req_signed`=1 and a non-zero divisor, the quotient is truncated toward zero. It is negative when the operand signs differ. The remainder takes the sign of the dividend and is smaller in magnitude than the divisor.
- R7: A divide by zero, signed or unsigned, completes with the normal latency. It gives `res_lo` = all ones and `res_hi` = the dividend, with no flag.
- R8: A signed divide of 0x80000000 by 0xFFFFFFFF gives `res_lo` = 0x80000000 and `res_hi` = 0, with no flag.
- R9: `res_hi` and `res_lo` change only on the edge that raises `done`, and they hold their value in between.
- R10: While reset is low, `busy`=0, `done`=0, `req_ready`=1, `res_hi`=0 and `res_lo`=0.
- R11: A request offered in the cycle where `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request (idle) |
| req_op | input | 1 | 0 = multiply, 1 = divide |
| req_signed | input | 1 | 1 = two's complement operands |
| req_a | input | 32 | Multiplicand or dividend |
| req_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 32 | Product upper half or remainder |
| res_lo | output | 32 | Product lower half or quotient |

## Verification
The assertions assume reset is held low from time zero until the first edges have passed. They also assume `req_op`, `req_signed` and the operands matter only on the accepting edge, so the properties place no condition on them at any other time. The stimulus changes every input on the falling edge only. It drops `req_valid` one cycle after offering a request, except in the cases built on purpose to offer one while busy or in the `done` cycle. Operands cover sign combinations, the most negative value, all ones, zero and a zero divisor.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } md_state_e;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_e;

endpackage

// File: rtl/muldiv_addsub.sv
module muldiv_addsub #(
  parameter int W = 32
) (
  input  logic [W:0] x,
  input  logic [W:0] y,
  input  logic       sub,
  output logic [W:0] sum,
  output logic       cout
);
  logic [W+1:0] full;
  logic [W:0]   y_eff;

  always_comb begin
    y_eff = sub ? ~y : y;
    full  = {1'b0, x} + {1'b0, y_eff} + {{(W+1){1'b0}}, sub};
    sum   = full[W:0];
    cout  = full[W+1];
  end
endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic busy,
  output logic accept,
  output logic in_setup,
  output logic in_iter,
  output logic in_fix,
  output logic done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  md_state_e     state;
  logic [CW-1:0] step_cnt;
  logic          last_step;

  assign last_step = (step_cnt == CW'(W - 1));
  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && (state == ST_IDLE);
  assign in_setup  = (state == ST_SETUP);
  assign in_iter   = (state == ST_ITER);
  assign in_fix    = (state == ST_FIX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE:  if (req_valid) state <= ST_SETUP;
        ST_SETUP: begin
          step_cnt <= '0;
          state    <= ST_ITER;
        end
        ST_ITER: begin
          if (last_step) state <= ST_FIX;
          else           step_cnt <= step_cnt + 1'b1;
        end
        ST_FIX: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: no acceptance window while an operation runs
  p_ready_only_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R2: done is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: setup is followed by iteration, sign-fix by done
  p_setup_then_iter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETUP) |=> (state == ST_ITER));

  p_fix_then_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIX) |=> (done && !busy));
endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         in_setup,
  input  logic         in_iter,
  input  logic         in_fix,
  input  logic         op_in,
  input  logic         sgn_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int PW = 2 * W;

  md_op_e       op_q;
  logic         sgn_q;
  logic [W-1:0] a_q, b_q;
  logic [W-1:0] acc;      // partial product high half / partial remainder
  logic [W-1:0] sr;       // multiplier bits / dividend bits then quotient
  logic [W-1:0] opnd;     // multiplicand or divisor magnitude
  logic         neg_prod, neg_quo, neg_rem;

  logic         a_neg, b_neg;
  logic [W-1:0] mag_a, mag_b;
  logic [W:0]   add_x, add_y, add_sum;
  logic         add_sub, add_cout;
  logic [PW-1:0] prod_raw, prod_fix;

  // operand magnitudes for the setup step
  always_comb begin
    a_neg = sgn_q && a_q[W-1];
    b_neg = sgn_q && b_q[W-1];
    mag_a = a_neg ? (~a_q + 1'b1) : a_q;
    mag_b = b_neg ? (~b_q + 1'b1) : b_q;
  end

  // operand selection for the one shared adder
  always_comb begin
    if (op_q == OP_DIV) begin
      add_x   = {acc, sr[W-1]};
      add_y   = {1'b0, opnd};
      add_sub = 1'b1;
    end else begin
      add_x   = {1'b0, acc};
      add_y   = {1'b0, (sr[0] ? opnd : {W{1'b0}})};
      add_sub = 1'b0;
    end
  end

  muldiv_addsub #(.W(W)) u_addsub (
    .x    (add_x),
    .y    (add_y),
    .sub  (add_sub),
    .sum  (add_sum),
    .cout (add_cout)
  );

  always_comb begin
    prod_raw = {acc, sr};
    prod_fix = neg_prod ? (~prod_raw + 1'b1) : prod_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_MUL;
      sgn_q    <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
      acc      <= '0;
      sr       <= '0;
      opnd     <= '0;
      neg_prod <= 1'b0;
      neg_quo  <= 1'b0;
      neg_rem  <= 1'b0;
      res_hi   <= '0;
      res_lo   <= '0;
    end else begin
      if (accept) begin
        op_q  <= md_op_e'(op_in);
        sgn_q <= sgn_in;
        a_q   <= a_in;
        b_q   <= b_in;
      end
      if (in_setup) begin
        acc      <= '0;
        sr       <= mag_a;
        opnd     <= mag_b;
        neg_prod <= a_neg ^ b_neg;
        neg_quo  <= (a_neg ^ b_neg) && (b_q != '0);
        neg_rem  <= a_neg;
      end
      if (in_iter) begin
        if (op_q == OP_DIV) begin
          // restoring step: keep the shifted remainder when the subtract borrows
          acc <= add_cout ? add_sum[W-1:0] : add_x[W-1:0];
          sr  <= {sr[W-2:0], add_cout};
        end else begin
          acc <= add_sum[W:1];
          sr  <= {add_sum[0], sr[W-1:1]};
        end
      end
      if (in_fix) begin
        if (op_q == OP_DIV) begin
          res_lo <= neg_quo ? (~sr + 1'b1) : sr;
          res_hi <= neg_rem ? (~acc + 1'b1) : acc;
        end else begin
          res_hi <= prod_fix[PW-1:W];
          res_lo <= prod_fix[W-1:0];
        end
      end
    end
  end

  // R3: a multiply step never carries out of the widened adder
  p_mul_no_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_iter && op_q == OP_MUL) |-> !add_cout);

  // R5: after every divide step the partial remainder stays below the divisor
  p_rem_below_divisor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_iter && op_q == OP_DIV && opnd != '0) |=> (acc < opnd));
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic             req_signed,
  input  logic [WIDTH-1:0] req_a,
  input  logic [WIDTH-1:0] req_b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] res_hi,
  output logic [WIDTH-1:0] res_lo
);
  logic accept, in_setup, in_iter, in_fix;

  muldiv_ctrl #(.W(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .accept    (accept),
    .in_setup  (in_setup),
    .in_iter   (in_iter),
    .in_fix    (in_fix),
    .done      (done)
  );

  muldiv_dp #(.W(WIDTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .in_setup (in_setup),
    .in_iter  (in_iter),
    .in_fix   (in_fix),
    .op_in    (req_op),
    .sgn_in   (req_signed),
    .a_in     (req_a),
    .b_in     (req_b),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
  );

  // R9: the result pair only moves together with done
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((res_hi != $past(res_hi)) || (res_lo != $past(res_lo))) |-> done);

  // R2: a new result never appears while still busy
  p_done_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/muldiv_seq_tb.sv
module muldiv_seq_tb;
  localparam int W   = 32;
  localparam int LAT = W + 3;  // falling edges from the accepting edge until done is seen
  localparam int NV  = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_op, req_signed;
  logic [W-1:0] req_a, req_b;
  logic         req_ready, busy, done;
  logic [W-1:0] res_hi, res_lo;

  int n_vec  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk = ~clk;  // 50 MHz

  muldiv_seq #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_signed(req_signed), .req_a(req_a), .req_b(req_b),
    .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
  );

  // {op, signed, a, b}
  localparam logic [65:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 32'd7,          32'd6},          // R3
    {1'b0, 1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF},   // R3
    {1'b0, 1'b0, 32'h12345678,   32'h9ABCDEF0},   // R3
    {1'b0, 1'b0, 32'd0,          32'hDEADBEEF},   // R3
    {1'b0, 1'b1, 32'hFFFFFFF9,   32'd6},          // R4
    {1'b0, 1'b1, 32'hFFFFFFFF,   32'hFFFFFFFF},   // R4
    {1'b0, 1'b1, 32'h80000000,   32'h80000000},   // R4
    {1'b0, 1'b1, 32'h7FFFFFFF,   32'h80000000},   // R4
    {1'b1, 1'b0, 32'd100,        32'd7},          // R5
    {1'b1, 1'b0, 32'hFFFFFFFF,   32'd16},         // R5
    {1'b1, 1'b0, 32'd5,          32'd9},          // R5
    {1'b1, 1'b1, 32'hFFFFFF9C,   32'd7},          // R6
    {1'b1, 1'b1, 32'd100,        32'hFFFFFFF9},   // R6
    {1'b1, 1'b1, 32'hFFFFFF9C,   32'hFFFFFFF9},   // R6
    {1'b1, 1'b1, 32'h80000000,   32'hFFFFFFFF},   // R8
    {1'b1, 1'b0, 32'd1234,       32'd0},          // R7
    {1'b1, 1'b1, 32'hFFFFFFFB,   32'd0},          // R7
    {1'b1, 1'b1, 32'h80000000,   32'd3}           // R6
  };

  function automatic logic [63:0] model(input logic op, input logic sgn,
                                        input logic [W-1:0] a, input logic [W-1:0] b);
    logic [63:0] r;
    logic signed [63:0] sa, sb;
    logic signed [31:0] qa, qb;
    sa = $signed({{32{a[31]}}, a});
    sb = $signed({{32{b[31]}}, b});
    qa = $signed(a);
    qb = $signed(b);
    if (!op) begin
      if (sgn) r = 64'(sa * sb);
      else     r = {32'd0, a} * {32'd0, b};
    end else if (b == '0) begin
      r = {a, 32'hFFFFFFFF};
    end else if (!sgn) begin
      r = {a % b, a / b};
    end else if (a == 32'h80000000 && b == 32'hFFFFFFFF) begin
      r = {32'd0, 32'h80000000};
    end else begin
      r = {32'(qa % qb), 32'(qa / qb)};
    end
    return r;
  endfunction

  function automatic string req_of(input logic op, input logic sgn,
                                   input logic [W-1:0] a, input logic [W-1:0] b);
    if (!op) return sgn ? "R4" : "R3";
    if (b == '0) return "R7";
    if (sgn && a == 32'h80000000 && b == 32'hFFFFFFFF) return "R8";
    return sgn ? "R6" : "R5";
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic start_req(input logic op, input logic sgn,
                           input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_signed = sgn; req_a = a; req_b = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 1;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [63:0] held;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0; req_signed = 1'b0;
    req_a = '0; req_b = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 outputs", {res_hi, res_lo}, 64'd0);
    chk("R10 flags", {61'd0, busy, done, req_ready}, 64'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic op, sg;
      logic [W-1:0] a, b;
      {op, sg, a, b} = VEC[i];
      start_req(op, sg, a, b);
      wait_done(lat);
      chk(req_of(op, sg, a, b), {res_hi, res_lo}, model(op, sg, a, b));
      chk("R2 latency", 64'(lat), 64'(LAT));
    end

    // R2: done lasts one cycle; R9: result holds afterwards
    held = {res_hi, res_lo};
    @(negedge clk);
    chk("R2 done pulse", {63'd0, done}, 64'd0);
    repeat (5) @(negedge clk);
    chk("R9 hold", {res_hi, res_lo}, held);

    // R1: a request offered while busy is ignored
    start_req(1'b0, 1'b0, 32'd3, 32'd5);
    repeat (3) @(negedge clk);
    chk("R1 ready low while busy", {62'd0, busy, req_ready}, 64'd2);
    req_valid = 1'b1; req_op = 1'b1; req_a = 32'd1000; req_b = 32'd3;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_done(lat);
    chk("R1 first result kept", {res_hi, res_lo}, 64'd15);
    begin
      int extra = 0;
      repeat (45) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R1 no second done", 64'(extra), 64'd0);
    end

    // R11: back-to-back request taken in the done cycle
    start_req(1'b0, 1'b0, 32'd9, 32'd9);
    wait_done(lat);
    chk("R11 first product", {res_hi, res_lo}, 64'd81);
    chk("R11 ready in done cycle", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_op = 1'b1; req_signed = 1'b0; req_a = 32'd81; req_b = 32'd4;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(lat);
    chk("R11 second result", {res_hi, res_lo}, {32'd1, 32'd20});
    chk("R11 latency", 64'(lat), 64'(LAT));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule